// File: doc/BRIEF.md
# Grouped-Priority DMA Channel Arbiter

This block decides which of several DMA channels may move data next. Every channel carries one bit that puts it in either the urgent group or the normal group. A request from the urgent group always beats a request from the normal group. Inside a group, the channel with the smaller index wins. The grant is registered and one-hot. It appears on the clock edge after the arbiter sees the request.

Once a channel holds the grant, it keeps it for a burst of 2^R data transfers. Each channel has its own R, given as a 4-bit field. Values above 10 are treated as 10. The transfer engine pulses a strobe for each completed transfer. It pulses a second strobe when the granted channel has finished its whole cycle, and that ends the burst early. In the cycle where a burst ends, the arbiter raises a rearbitration pulse and loads the next winner on the same edge, so no idle cycle is inserted between grants. A request that arrives while a burst is running waits for that burst to end, even if it has higher priority.

Top module: `dma_grp_arbiter`

## Requirements
- R1: During reset and on the first edge after it, `grant_o` is all zeros and `rearb_o` is 0.
- R2: When a new grant is chosen, any requesting channel whose `urgent_i` bit is 1 wins over every requesting channel whose bit is 0.
- R3: Among the requesters of the winning group, the channel with the lowest index is granted.
- R4: With no requests, the next grant is all zeros. When `grant_o` is zero and `req_i` is non-zero at a rising edge, a grant is visible after that edge.
- R5: A burst ends in the cycle that carries the 2^R-th `xfer_done_i` pulse since the grant was loaded. In that cycle `rearb_o` is 1, and the next winner, which may be the same channel, is loaded at the following edge.
- R6: While a burst runs, `grant_o` does not change unless `rearb_o` is 1, whatever requests arrive.
- R7: A `cycle_end_i` pulse while a channel is granted ends the burst at once, with `rearb_o` high in that cycle, even if fewer than 2^R transfers have been counted.
- R8: Channel i's R sits in `rate_i[4*i+3:4*i]`. Any value from 11 to 15 gives a burst of 1024 transfers.
- R9: When no channel is granted, `xfer_done_i` and `cycle_end_i` are ignored: `rearb_o` stays 0, and the transfer count of the next burst starts from zero.
- R10: `grant_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NCH | Request per channel |
| urgent_i | input | NCH | Group select per channel, 1 = urgent group |
| rate_i | input | 4*NCH | Burst exponent R per channel, 4 bits each |
| xfer_done_i | input | 1 | One transfer of the granted channel finished |
| cycle_end_i | input | 1 | The granted channel finished its whole cycle |
| grant_o | output | NCH | One-hot registered grant, zero when idle |
| rearb_o | output | 1 | High in the cycle where the current burst ends |

## Verification
The assertions assume the strobes describe the granted channel only, so a completion pulse seen while idle must leave no trace. They also assume that the request and group vectors are sampled only at a clock edge. The stimulus applies every input change half a period away from the rising edge and holds it for one full cycle. Idle-time strobes are driven on purpose, to show that they are dropped. Rate fields above 10 and mid-burst arrivals of urgent requests stay within those assumptions, and they exercise the clamp and the no-preemption rule.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int ARB_RW   = 4;
  localparam int ARB_RMAX = 10;
  localparam int ARB_CW   = ARB_RMAX + 2;

  function automatic logic [ARB_CW-1:0] burst_len(input logic [ARB_RW-1:0] r);
    logic [ARB_RW-1:0] rc;
    rc = (r > ARB_RW'(ARB_RMAX)) ? ARB_RW'(ARB_RMAX) : r;
    return ARB_CW'(1) << rc;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] urgent,
  output logic [NCH-1:0] win
);
  logic [NCH-1:0] urg_req;
  logic [NCH-1:0] pool;
  logic [NCH:0]   taken;

  assign urg_req  = req & urgent;
  assign pool     = (|urg_req) ? urg_req : req;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign win[i]     = pool[i] & ~taken[i];
    assign taken[i+1] = taken[i] | pool[i];
  end
endmodule

// File: rtl/dma_arb_burst.sv
module dma_arb_burst
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              xfer,
  input  logic [ARB_RW-1:0] rate,
  output logic              last
);
  logic [ARB_CW-1:0] cnt_q;

  assign last = xfer && ((cnt_q + ARB_CW'(1)) == burst_len(rate));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (xfer)    cnt_q <= cnt_q + ARB_CW'(1);
  end
endmodule

// File: rtl/dma_grp_arbiter.sv
module dma_grp_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        req_i,
  input  logic [NCH-1:0]        urgent_i,
  input  logic [NCH*ARB_RW-1:0] rate_i,
  input  logic                  xfer_done_i,
  input  logic                  cycle_end_i,
  output logic [NCH-1:0]        grant_o,
  output logic                  rearb_o
);
  logic [NCH-1:0]    grant_q;
  logic [NCH-1:0]    win_w;
  logic [ARB_RW-1:0] cur_rate_w;
  logic              busy_w;
  logic              burst_last_w;
  logic              release_w;
  logic              load_w;

  function automatic logic [ARB_RW-1:0] rate_of(input logic [NCH-1:0] g,
                                                input logic [NCH*ARB_RW-1:0] r);
    logic [ARB_RW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NCH; i++)
      if (g[i]) acc = acc | r[i*ARB_RW +: ARB_RW];
    return acc;
  endfunction

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .req    (req_i),
    .urgent (urgent_i),
    .win    (win_w)
  );

  assign busy_w     = |grant_q;
  assign cur_rate_w = rate_of(grant_q, rate_i);

  dma_arb_burst u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_w),
    .xfer    (xfer_done_i && busy_w),
    .rate    (cur_rate_w),
    .last    (burst_last_w)
  );

  assign release_w = busy_w && (cycle_end_i || burst_last_w);
  assign load_w    = !busy_w || release_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grant_q <= '0;
    else if (load_w) grant_q <= win_w;
  end

  assign grant_o = grant_q;
  assign rearb_o = release_w;
endmodule

// File: rtl/dma_grp_arbiter_chk.sv
module dma_grp_arbiter_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] urgent_i,
  input logic           xfer_done_i,
  input logic           cycle_end_i,
  input logic [NCH-1:0] grant_o,
  input logic           rearb_o,
  input logic           busy_w
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && (grant_o == '0 || rearb_o)) |=> grant_o == '0);

  // R4
  prompt_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0 && req_i != '0) |=> grant_o != '0);

  // R6
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !rearb_o) |=> $stable(grant_o));

  // R2
  urgent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_w == 1'b0 || rearb_o) && (req_i & urgent_i) != '0)
      |=> (grant_o & $past(urgent_i)) != '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !rearb_o);

  // R5
  burst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb_o && !cycle_end_i) |-> xfer_done_i);
endmodule

bind dma_grp_arbiter dma_grp_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .urgent_i    (urgent_i),
  .xfer_done_i (xfer_done_i),
  .cycle_end_i (cycle_end_i),
  .grant_o     (grant_o),
  .rearb_o     (rearb_o),
  .busy_w      (busy_w)
);

// File: tb/dma_grp_arbiter_tb.sv
module dma_grp_arbiter_tb;
  localparam int NCH = 8;
  localparam int RW  = 4;

  typedef struct {
    logic [NCH-1:0] exp_grant;
    logic           exp_rearb;
    logic           got_rearb;
    string          tag;
  } item_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NCH-1:0]      req_i = '0;
  logic [NCH-1:0]      urgent_i = '0;
  logic [NCH*RW-1:0]   rate_i = '0;
  logic                xfer_done_i = 1'b0;
  logic                cycle_end_i = 1'b0;
  logic [NCH-1:0]      grant_o;
  logic                rearb_o;

  int checks = 0;
  int errors = 0;
  item_t sb[$];
  int m_idx = -1;
  int m_cnt = 0;

  always #4 clk = ~clk;

  dma_grp_arbiter #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .urgent_i(urgent_i),
    .rate_i(rate_i), .xfer_done_i(xfer_done_i), .cycle_end_i(cycle_end_i),
    .grant_o(grant_o), .rearb_o(rearb_o)
  );

  task automatic set_rate(input int ch, input int r);
    rate_i[ch*RW +: RW] = RW'(r);
  endtask

  function automatic int model_pick(input logic [NCH-1:0] rq, input logic [NCH-1:0] ur);
    for (int i = 0; i < NCH; i++) if (rq[i] && ur[i]) return i;
    for (int i = 0; i < NCH; i++) if (rq[i]) return i;
    return -1;
  endfunction

  task automatic step(input logic [NCH-1:0] rq, input logic [NCH-1:0] ur,
                      input logic xd, input logic ce, input string tag);
    item_t it;
    int    r;
    int    lim;
    logic  rel;
    @(negedge clk);
    req_i = rq; urgent_i = ur; xfer_done_i = xd; cycle_end_i = ce;
    #1;
    rel = 1'b0;
    if (m_idx >= 0) begin
      r   = int'(rate_i[m_idx*RW +: RW]);
      if (r > 10) r = 10;
      lim = 1 << r;
      rel = ce || (xd && (m_cnt + 1 == lim));
      if (!rel && xd) m_cnt++;
    end
    if (m_idx < 0 || rel) begin
      m_idx = model_pick(rq, ur);
      m_cnt = 0;
    end
    it.exp_grant = (m_idx < 0) ? '0 : (NCH'(1) << m_idx);
    it.exp_rearb = rel;
    it.got_rearb = rearb_o;
    it.tag       = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      #1;
      checks++;
      if (grant_o !== it.exp_grant || it.got_rearb !== it.exp_rearb) begin
        errors++;
        $display("FAIL %s grant=%b rearb=%b expected grant=%b rearb=%b",
                 it.tag, grant_o, it.got_rearb, it.exp_grant, it.exp_rearb);
      end
    end
  end

  task automatic finish_run;
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (grant_o !== '0 || rearb_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 grant=%b rearb=%b expected 0 0", grant_o, rearb_o);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1 and R4: no requests keep the grant at zero
    step('0, '0, 0, 0, "R1");
    step('0, '0, 0, 0, "R4");
    // R9: strobes while idle are ignored
    set_rate(2, 1);
    step('0, '0, 1, 0, "R9");
    step('0, '0, 0, 1, "R9");
    step('0, '0, 1, 0, "R9");
    // R4: grant follows the request by one edge
    step(8'b0000_0100, '0, 0, 0, "R4");
    step(8'b0000_0100, '0, 1, 0, "R9");
    step(8'b0000_0100, '0, 1, 0, "R5");
    step('0, '0, 1, 0, "R5");
    step('0, '0, 0, 0, "R4");

    // R5: R=0 gives single-transfer bursts, same channel granted again
    set_rate(3, 0);
    step(8'b0000_1000, '0, 0, 0, "R4");
    step(8'b0000_1000, '0, 1, 0, "R5");
    step(8'b0000_1000, '0, 1, 0, "R5");

    // R2: urgent ch5 beats normal ch1 and ch3
    set_rate(5, 0); set_rate(1, 0);
    step(8'b0010_1010, 8'b0010_0000, 1, 0, "R2");
    step(8'b0010_1010, 8'b0010_0000, 0, 0, "R2");
    // R3: once ch5 leaves, lowest normal index wins
    step(8'b0000_1010, 8'b0010_0000, 1, 0, "R3");
    step(8'b0000_1010, 8'b0000_0000, 0, 0, "R3");
    step(8'b0000_1010, 8'b0000_1010, 0, 1, "R3");
    step(8'b0000_1000, 8'b0000_1010, 0, 1, "R3");
    step('0, '0, 0, 1, "R4");
    step('0, '0, 0, 0, "R4");

    // R6: burst of 4 on ch0, urgent ch7 arrives mid-burst
    set_rate(0, 2); set_rate(7, 0);
    step(8'b0000_0001, '0, 0, 0, "R4");
    step(8'b0000_0001, '0, 1, 0, "R6");
    step(8'b1000_0001, 8'b1000_0000, 1, 0, "R6");
    step(8'b1000_0001, 8'b1000_0000, 0, 0, "R6");
    step(8'b1000_0001, 8'b1000_0000, 1, 0, "R6");
    step(8'b1000_0001, 8'b1000_0000, 1, 0, "R5");
    step(8'b0000_0001, 8'b1000_0000, 1, 0, "R2");

    // R7: early end of cycle on ch0 with R=2
    step(8'b0000_0001, '0, 1, 0, "R7");
    step(8'b0000_0001, '0, 1, 0, "R7");
    step(8'b0000_0100, '0, 0, 1, "R7");
    step('0, '0, 0, 1, "R7");
    step('0, '0, 0, 0, "R7");

    // R8: ch6 with field 15 clamps to 1024 transfers
    set_rate(6, 15);
    step(8'b0100_0000, '0, 0, 0, "R8");
    for (int k = 0; k < 1023; k++) step(8'b0100_0000, '0, 1, 0, "R8");
    step(8'b0000_0010, '0, 1, 0, "R8");
    // R8: ch1 with field 10 also bursts 1024
    set_rate(1, 10);
    for (int k = 0; k < 1023; k++) step(8'b0000_0010, '0, 1, 0, "R8");
    step('0, '0, 1, 0, "R8");
    step('0, '0, 0, 0, "R10");

    finish_run();
  end
endmodule